// File: doc/BRIEF.md
# Interrupt Acknowledge Dispatch Unit

This block is one slice of a memory-mapped interrupt controller that serves two processor cores. It watches a small set of interrupt source lines. Each source has its own priority, vector, sense type (edge or level) and destination mask. A pending bit is kept for each source, and an in-service bit is kept for each source on each core. Each core has one interrupt output. The output is raised when that core has a routed, pending source whose priority is higher than anything the core is already servicing.

Software talks to the block through one register bus. Each access carries a requester identity, and a small per-requester window resolves against that identity. A read of the acknowledge location in that window is the acknowledge itself, with side effects in the cycle the read is accepted. It returns the winning vector, marks the source in service, clears the pending bit of an edge source and drops the caller's interrupt line. An empty acknowledge returns a programmable spurious vector. A write to the end-of-interrupt location retires the highest-priority in-service source of the caller. A read-only identity location tells a core which destination-mask bit belongs to it.

The request channel is valid/ready. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high. Each accepted request returns exactly one response, with `rsp_valid` high in the next cycle. The response channel cannot be stalled, so the requester must take it in that cycle. A response to a write carries zero data.

Top module: `irq_ack_dispatch`

## Requirements
- R1: A read of the acknowledge location (offset 0x0A0) by core c returns, in bits [7:0], the vector of the highest-priority source that is pending, routed to c and not in service on c. Among sources of equal priority, the lowest index wins.
- R2: An acknowledge read that finds no candidate returns the spurious vector register (offset 0x1FC, bits [7:0]) and has no side effects. An acknowledge read from a requester other than a core behaves the same way.
- R3: An acknowledge read clears the winning source's pending bit only for an edge source (config bit 16 = 0). A level source (bit 16 = 1) stays pending for as long as its input is high and stops being pending once the input is low.
- R4: An acknowledge read marks the winning source in service on the reading core. While it is in service, it is not returned again to that core, and it blocks that core's output against pending sources of lower or equal priority.
- R5: In the cycle after an acknowledge read is accepted, the reading core's interrupt output is low.
- R6: `core_int[c]` is high when the best candidate for core c has a priority strictly greater than the highest priority in service on c. The output is registered, so it follows the source inputs two cycles later. Priority 0 (config bits [11:8]) disables a source.
- R7: A write to the end-of-interrupt location (offset 0x0B0) by core c clears the in-service bit of c's highest-priority in-service source, with the lowest index winning a tie. The output is re-evaluated in the following cycle.
- R8: The identity location (offset 0x090) reads the requester identity in bits [4:0]: 0 for core 0, 1 for core 1, and 0x1F for any other requester. Bits [31:5] read as zero, and writes to it have no effect.
- R9: Source i is configured at offset 0x100 + 4*i: vector in bits [7:0], priority in bits [11:8], level in bit 16, destination mask in bits [25:24] (bit 24 for core 0). A source reaches only the cores set in its mask, and the configuration reads back as written.
- R10: `req_ready` is high after reset. Every accepted request gives `rsp_valid` high in the next cycle, and only then. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Interrupt source lines |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_id | input | 5 | Requester identity (0, 1 = cores) |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Response data |
| core_int | output | 2 | Per-core interrupt output |

## Verification
A corrupted in-service bit shows at the ports within two cycles, in one of two ways. Either an interrupt line stays low although a higher-priority source is pending, or an acknowledge returns a vector that should have been masked. The bench exposes a wrong end-of-interrupt choice by re-raising a source whose priority lies between the two in-service ones and watching the line. A stuck edge pending bit shows on the next acknowledge read as a repeated vector instead of the spurious one. A missed negation after an acknowledge shows one cycle after the read as a line that is still high.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int NUM_CORE  = 2;
  localparam int CORE_W    = 1;
  localparam int ID_W      = 5;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int VEC_W     = 8;
  localparam int PRIO_W    = 4;

  localparam int PRIO_LSB  = 8;
  localparam int LEVEL_BIT = 16;
  localparam int DEST_LSB  = 24;

  localparam logic [ADDR_W-1:0] OFS_WHOAMI = 12'h090;
  localparam logic [ADDR_W-1:0] OFS_IACK   = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_EOI    = 12'h0B0;
  localparam logic [ADDR_W-1:0] SRC_BASE   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_SPUR   = 12'h1FC;

  typedef struct packed {
    logic [NUM_CORE-1:0] dest;
    logic                level;
    logic [PRIO_W-1:0]   prio;
    logic [VEC_W-1:0]    vec;
  } src_cfg_t;

  function automatic logic [DATA_W-1:0] cfg_to_word(input src_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_W-1:0]               = c.vec;
    w[PRIO_LSB +: PRIO_W]      = c.prio;
    w[LEVEL_BIT]               = c.level;
    w[DEST_LSB +: NUM_CORE]    = c.dest;
    return w;
  endfunction

  function automatic src_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
    src_cfg_t c;
    c.vec   = w[VEC_W-1:0];
    c.prio  = w[PRIO_LSB +: PRIO_W];
    c.level = w[LEVEL_BIT];
    c.dest  = w[DEST_LSB +: NUM_CORE];
    return c;
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter  int N  = 8,
  parameter  int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 found,
  output logic [IW-1:0]        idx,
  output logic [PW-1:0]        best
);
  // Strict greater-than keeps the lowest index on a tie; priority 0 never wins.
  always_comb begin
    best = '0;
    idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (prio[i] > best)) begin
        best = prio[i];
        idx  = IW'(i);
      end
    end
    found = (best != '0);
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_ack_pkg::*;
#(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        irq_in,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_idx,
  input  src_cfg_t            cfg_wdata,
  input  logic                clr_en,
  input  logic [IW-1:0]       clr_idx,
  output src_cfg_t [N-1:0]    cfg,
  output logic [N-1:0]        pend
);
  src_cfg_t [N-1:0] cfg_q;
  logic [N-1:0]     irq_q;
  logic [N-1:0]     edge_q;
  logic [N-1:0]     rise;
  logic [N-1:0]     clr_hot;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rise[i]    = irq_in[i] & ~irq_q[i];
      clr_hot[i] = clr_en && (clr_idx == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      irq_q  <= '0;
      edge_q <= '0;
    end else begin
      irq_q  <= irq_in;
      // a fresh edge in the acknowledge cycle survives the clear
      edge_q <= rise | (edge_q & ~clr_hot);
      for (int i = 0; i < N; i++) begin
        if (cfg_we && (cfg_idx == IW'(i))) cfg_q[i] <= cfg_wdata;
      end
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_pend
      assign pend[g] = cfg_q[g].level ? irq_q[g] : edge_q[g];
    end
  endgenerate

  assign cfg = cfg_q;
endmodule

// File: rtl/irq_core_ctx.sv
module irq_core_ctx
  import irq_ack_pkg::*;
#(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            pend,
  input  logic [N-1:0]            routed,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  input  logic                    ack_en,
  input  logic                    eoi_en,
  output logic                    found,
  output logic [IW-1:0]           idx,
  output logic [N-1:0]            isr,
  output logic                    core_int
);
  logic [N-1:0]      isr_q;
  logic [N-1:0]      cand;
  logic [PRIO_W-1:0] p_best;
  logic              s_found;
  logic [IW-1:0]     s_idx;
  logic [PRIO_W-1:0] s_best;
  logic              int_q;

  assign cand = pend & routed & ~isr_q;

  irq_prio_pick #(.N(N), .PW(PRIO_W)) u_pend_pick (
    .cand (cand), .prio (prio), .found (found), .idx (idx), .best (p_best)
  );

  irq_prio_pick #(.N(N), .PW(PRIO_W)) u_svc_pick (
    .cand (isr_q), .prio (prio), .found (s_found), .idx (s_idx), .best (s_best)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      int_q <= 1'b0;
    end else begin
      if (ack_en && found)        isr_q[idx]   <= 1'b1;
      else if (eoi_en && s_found) isr_q[s_idx] <= 1'b0;
      int_q <= ack_en ? 1'b0 : (found && (p_best > s_best));
    end
  end

  assign isr      = isr_q;
  assign core_int = int_q;
endmodule

// File: rtl/irq_ack_dispatch.sv
module irq_ack_dispatch
  import irq_ack_pkg::*;
#(
  parameter  int NUM_SRC = 8,
  localparam int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [ID_W-1:0]     req_id,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [NUM_CORE-1:0] core_int
);
  localparam logic [ADDR_W-1:0] SRC_SPAN = ADDR_W'(4 * NUM_SRC);

  src_cfg_t [NUM_SRC-1:0]                 cfg;
  logic [NUM_SRC-1:0]                     pend_vec;
  logic [NUM_SRC-1:0][PRIO_W-1:0]         prio_vec;
  logic [NUM_CORE-1:0][NUM_SRC-1:0]       routed;
  logic [NUM_CORE-1:0][NUM_SRC-1:0]       isr_all;
  logic [NUM_CORE-1:0]                    ack_en;
  logic [NUM_CORE-1:0]                    eoi_en;
  logic [NUM_CORE-1:0]                    ack_found;
  logic [NUM_CORE-1:0][IW-1:0]            ack_idx;

  logic                is_core;
  logic [CORE_W-1:0]   core_sel;
  logic                rd_acc;
  logic                wr_acc;
  logic [ADDR_W-1:0]   src_off;
  logic                src_hit;
  logic [IW-1:0]       src_idx;
  logic                clr_en;
  logic [DATA_W-1:0]   rd_word;
  logic [VEC_W-1:0]    spur_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;
  logic                unused_bits;

  assign req_ready = 1'b1;
  assign is_core   = (req_id < ID_W'(NUM_CORE));
  assign core_sel  = req_id[CORE_W-1:0];
  assign rd_acc    = req_valid && !req_write;
  assign wr_acc    = req_valid && req_write;

  assign src_off = req_addr - SRC_BASE;
  assign src_hit = (req_addr >= SRC_BASE) && (src_off < SRC_SPAN) && (src_off[1:0] == 2'b00);
  assign src_idx = src_off[IW+1:2];

  assign unused_bits = ^{src_off[ADDR_W-1:IW+2], req_wdata[DATA_W-1:DEST_LSB+NUM_CORE],
                         req_wdata[DEST_LSB-1:LEVEL_BIT+1], req_wdata[LEVEL_BIT-1:PRIO_LSB+PRIO_W],
                         req_id[ID_W-1:CORE_W]};

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_vec
      assign prio_vec[s] = cfg[s].prio;
      for (genvar c = 0; c < NUM_CORE; c++) begin : g_route
        assign routed[c][s] = cfg[s].dest[c];
      end
    end
  endgenerate

  generate
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign ack_en[c] = rd_acc && (req_addr == OFS_IACK) && is_core && (core_sel == CORE_W'(c));
      assign eoi_en[c] = wr_acc && (req_addr == OFS_EOI)  && is_core && (core_sel == CORE_W'(c));

      irq_core_ctx #(.N(NUM_SRC)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_vec),
        .routed   (routed[c]),
        .prio     (prio_vec),
        .ack_en   (ack_en[c]),
        .eoi_en   (eoi_en[c]),
        .found    (ack_found[c]),
        .idx      (ack_idx[c]),
        .isr      (isr_all[c]),
        .core_int (core_int[c])
      );
    end
  endgenerate

  assign clr_en = |(ack_en & ack_found);

  irq_src_bank #(.N(NUM_SRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .cfg_we    (wr_acc && src_hit),
    .cfg_idx   (src_idx),
    .cfg_wdata (word_to_cfg(req_wdata)),
    .clr_en    (clr_en),
    .clr_idx   (ack_idx[core_sel]),
    .cfg       (cfg),
    .pend      (pend_vec)
  );

  always_comb begin
    rd_word = '0;
    if (!req_write) begin
      if (req_addr == OFS_WHOAMI) begin
        rd_word[ID_W-1:0] = is_core ? req_id : '1;
      end else if (req_addr == OFS_IACK) begin
        rd_word[VEC_W-1:0] = (is_core && ack_found[core_sel]) ? cfg[ack_idx[core_sel]].vec : spur_q;
      end else if (req_addr == OFS_SPUR) begin
        rd_word[VEC_W-1:0] = spur_q;
      end else if (src_hit) begin
        rd_word = cfg_to_word(cfg[src_idx]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spur_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (wr_acc && (req_addr == OFS_SPUR)) spur_q <= req_wdata[VEC_W-1:0];
      rsp_valid_q <= req_valid;
      rsp_rdata_q <= req_valid ? rd_word : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/irq_ack_dispatch_chk.sv
module irq_ack_dispatch_chk
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic                             req_write,
  input logic [ADDR_W-1:0]                req_addr,
  input logic [ID_W-1:0]                  req_id,
  input logic                             rsp_valid,
  input logic [DATA_W-1:0]                rsp_rdata,
  input logic [NUM_CORE-1:0]              core_int,
  input logic [NUM_SRC-1:0]               pend_vec,
  input logic [NUM_CORE-1:0][NUM_SRC-1:0] isr_all
);
  AST_RSP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_RSP_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10
  AST_ACK_DROPS_INT0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFS_IACK && req_id == 5'd0) |=> !core_int[0]); // R5
  AST_ACK_DROPS_INT1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFS_IACK && req_id == 5'd1) |=> !core_int[1]); // R5
  AST_WHOAMI_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFS_WHOAMI) |=> (rsp_rdata[DATA_W-1:ID_W] == '0)); // R8
  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_int[0]) |-> $past(|pend_vec)); // R6
  AST_SVC_GROWS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(isr_all[0]) > $countones($past(isr_all[0]))) |->
      $past(req_valid && !req_write && req_addr == OFS_IACK && req_id == 5'd0)); // R4
  AST_EOI_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFS_EOI && req_id == 5'd0) |=>
      ($countones(isr_all[0]) <= $countones($past(isr_all[0])))); // R7
endmodule

bind irq_ack_dispatch irq_ack_dispatch_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_id    (req_id),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .core_int  (core_int),
  .pend_vec  (pend_vec),
  .isr_all   (isr_all)
);

// File: tb/tb_irq_ack_dispatch.sv
module tb_irq_ack_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  req_id = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  core_int;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ack_dispatch #(.NUM_SRC(8)) dut (
    .clk (clk), .rst_n (rst_n), .irq_in (irq_in),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_id (req_id),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .core_int (core_int)
  );

  // entry: {op, req, id, addr, data, exp}; op 0 write, 1 read, 2 set irq_in, 3 check core_int
  localparam int NV = 53;
  localparam logic [91:0] TBL [NV] = '{
    {4'd0, 4'd9,  8'd0, 12'h100, 32'h01000320, 32'h0},        // R9 src0 v20 p3 edge core0
    {4'd0, 4'd9,  8'd0, 12'h104, 32'h03010521, 32'h0},        // R9 src1 v21 p5 level both
    {4'd0, 4'd9,  8'd0, 12'h108, 32'h01000522, 32'h0},        // R9 src2 v22 p5 edge core0
    {4'd0, 4'd9,  8'd0, 12'h10C, 32'h02000723, 32'h0},        // R9 src3 v23 p7 edge core1
    {4'd0, 4'd6,  8'd0, 12'h110, 32'h03000024, 32'h0},        // R6 src4 p0 both
    {4'd0, 4'd2,  8'd0, 12'h1FC, 32'h000000FF, 32'h0},        // R2 spurious
    {4'd1, 4'd2,  8'd0, 12'h1FC, 32'h0,        32'h000000FF}, // R2
    {4'd1, 4'd9,  8'd1, 12'h104, 32'h0,        32'h03010521}, // R9 readback
    {4'd3, 4'd6,  8'd0, 12'h0,   32'h0,        32'h0},        // R6
    {4'd1, 4'd2,  8'd0, 12'h0A0, 32'h0,        32'h000000FF}, // R2 empty ack
    {4'd2, 4'd6,  8'd0, 12'h0,   32'h10,       32'h0},
    {4'd3, 4'd6,  8'd0, 12'h0,   32'h0,        32'h0},        // R6 prio 0 silent
    {4'd1, 4'd6,  8'd0, 12'h0A0, 32'h0,        32'h000000FF}, // R6
    {4'd2, 4'd9,  8'd0, 12'h0,   32'h15,       32'h0},
    {4'd3, 4'd9,  8'd0, 12'h0,   32'h0,        32'h1},        // R9 core0 only
    {4'd1, 4'd9,  8'd1, 12'h0A0, 32'h0,        32'h000000FF}, // R9 core1 empty
    {4'd3, 4'd2,  8'd0, 12'h0,   32'h0,        32'h1},        // R2 no side effect
    {4'd1, 4'd1,  8'd0, 12'h0A0, 32'h0,        32'h22},       // R1
    {4'd3, 4'd4,  8'd0, 12'h0,   32'h0,        32'h0},        // R4 p3 blocked by p5
    {4'd1, 4'd1,  8'd0, 12'h0A0, 32'h0,        32'h20},       // R1
    {4'd1, 4'd3,  8'd0, 12'h0A0, 32'h0,        32'h000000FF}, // R3 edge cleared
    {4'd0, 4'd7,  8'd0, 12'h0B0, 32'h0,        32'h0},        // R7 retire src2
    {4'd2, 4'd7,  8'd0, 12'h0,   32'h11,       32'h0},
    {4'd2, 4'd7,  8'd0, 12'h0,   32'h15,       32'h0},
    {4'd3, 4'd7,  8'd0, 12'h0,   32'h0,        32'h1},        // R7 p5 beats remaining p3
    {4'd1, 4'd3,  8'd0, 12'h0A0, 32'h0,        32'h22},       // R3 new edge captured
    {4'd0, 4'd7,  8'd0, 12'h0B0, 32'h0,        32'h0},
    {4'd0, 4'd7,  8'd0, 12'h0B0, 32'h0,        32'h0},
    {4'd3, 4'd7,  8'd0, 12'h0,   32'h0,        32'h0},        // R7
    {4'd2, 4'd9,  8'd0, 12'h0,   32'h02,       32'h0},
    {4'd3, 4'd9,  8'd0, 12'h0,   32'h0,        32'h3},        // R9 both cores
    {4'd1, 4'd1,  8'd1, 12'h0A0, 32'h0,        32'h21},       // R1
    {4'd3, 4'd5,  8'd0, 12'h0,   32'h0,        32'h1},        // R5
    {4'd1, 4'd3,  8'd0, 12'h0A0, 32'h0,        32'h21},       // R3 level stays pending
    {4'd3, 4'd5,  8'd0, 12'h0,   32'h0,        32'h0},        // R5
    {4'd2, 4'd6,  8'd0, 12'h0,   32'h0A,       32'h0},
    {4'd3, 4'd6,  8'd0, 12'h0,   32'h0,        32'h2},        // R6 p7 over p5
    {4'd1, 4'd1,  8'd1, 12'h0A0, 32'h0,        32'h23},       // R1
    {4'd3, 4'd5,  8'd0, 12'h0,   32'h0,        32'h0},        // R5
    {4'd0, 4'd7,  8'd1, 12'h0B0, 32'h0,        32'h0},        // R7 retire p7
    {4'd3, 4'd7,  8'd0, 12'h0,   32'h0,        32'h0},        // R7
    {4'd0, 4'd7,  8'd1, 12'h0B0, 32'h0,        32'h0},
    {4'd3, 4'd7,  8'd0, 12'h0,   32'h0,        32'h2},        // R7
    {4'd0, 4'd7,  8'd0, 12'h0B0, 32'h0,        32'h0},
    {4'd3, 4'd7,  8'd0, 12'h0,   32'h0,        32'h3},        // R7
    {4'd2, 4'd1,  8'd0, 12'h0,   32'h06,       32'h0},
    {4'd1, 4'd1,  8'd0, 12'h0A0, 32'h0,        32'h21},       // R1 tie -> lower index
    {4'd1, 4'd1,  8'd0, 12'h0A0, 32'h0,        32'h22},       // R1
    {4'd0, 4'd7,  8'd0, 12'h0B0, 32'h0,        32'h0},
    {4'd0, 4'd7,  8'd0, 12'h0B0, 32'h0,        32'h0},
    {4'd2, 4'd3,  8'd0, 12'h0,   32'h00,       32'h0},
    {4'd3, 4'd3,  8'd0, 12'h0,   32'h0,        32'h0},        // R3 level follows input
    {4'd1, 4'd3,  8'd1, 12'h0A0, 32'h0,        32'h000000FF}  // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [4:0] id, input logic [11:0] addr,
                     input logic [31:0] wd, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_id = id; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    rv = rsp_valid; rd = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R10 reset req_ready", {31'b0, req_ready}, 32'h1);
    check("R6 reset core_int", {30'b0, core_int}, 32'h0);
    bus(1'b0, 5'd0, 12'h100, 32'h0, rd, rv);
    check("R9 reset config", rd, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [91:0] e;
      string tag;
      e = TBL[k];
      tag = $sformatf("R%0d step %0d", e[87:84], k);
      case (e[91:88])
        4'd0: begin
          bus(1'b1, e[80:76], e[75:64], e[63:32], rd, rv);
          check({tag, " write rsp"}, {rv, rd[30:0]}, 32'h80000000);
        end
        4'd1: begin
          bus(1'b0, e[80:76], e[75:64], 32'h0, rd, rv);
          check({tag, " read valid"}, {31'b0, rv}, 32'h1);
          check({tag, " read data"}, rd, e[31:0]);
        end
        4'd2: begin
          @(negedge clk);
          irq_in = e[39:32];
        end
        default: begin
          repeat (2) @(negedge clk);
          check({tag, " core_int"}, {30'b0, core_int}, e[31:0]);
        end
      endcase
    end

    // R8 identity per requester
    bus(1'b0, 5'd0, 12'h090, 32'h0, rd, rv);
    check("R8 identity core0", rd, 32'h0);
    bus(1'b0, 5'd1, 12'h090, 32'h0, rd, rv);
    check("R8 identity core1", rd, 32'h1);
    bus(1'b0, 5'd2, 12'h090, 32'h0, rd, rv);
    check("R8 identity other", rd, 32'h1F);
    bus(1'b0, 5'd31, 12'h090, 32'h0, rd, rv);
    check("R8 identity other 31", rd, 32'h1F);
    bus(1'b1, 5'd1, 12'h090, 32'hFFFFFFFF, rd, rv);
    bus(1'b0, 5'd1, 12'h090, 32'h0, rd, rv);
    check("R8 identity write ignored", rd, 32'h1);

    // R10 no response without a request
    @(negedge clk);
    check("R10 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

    // R2 other requester acknowledge has no side effect
    @(negedge clk);
    irq_in = 8'h01;
    repeat (2) @(negedge clk);
    check("R2 pre core_int", {30'b0, core_int}, 32'h1);
    bus(1'b0, 5'd7, 12'h0A0, 32'h0, rd, rv);
    check("R2 other ack spurious", rd, 32'hFF);
    @(negedge clk);
    check("R2 other ack keeps int", {30'b0, core_int}, 32'h1);
    bus(1'b0, 5'd0, 12'h0A0, 32'h0, rd, rv);
    check("R1 ack after other", rd, 32'h20);
    check("R5 int low after ack", {30'b0, core_int}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule